// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a small set of output pins for an SPI master. Each pin is either a chip select or a plain general-purpose output, and each pin has its own polarity control. Active-low and active-high selects can therefore sit side by side. Software programs the pin roles and polarities through a configuration write. It then moves individual output latches through a fast-access write. In that write the upper byte lane sets latches and the lower byte lane clears them, so no read-modify-write is needed.

Chip selects are numbered from 1, and select number n lives at bit n−1 of either lane. Asserting a select clears its latch. Releasing the select sets the latch. With polarity inversion off, the pin is therefore driven low while the select is asserted. The pin count is a parameter: a small build has 3 pins and a larger build has 6. Any setup and hold delays around transfers are produced by the transfer sequencer, not by this block.

Top module: `cs_pin_ctrl`

## Requirements
- R1: After reset, all latches, chip-select role bits and inversion bits are 0, so `latchStat`, `csMode` and `pinOut` all read 0.
- R2: A fast-access write with bit 8+k of `fastWrData` set, and bit k clear, sets latch k. Latch k is the latch of select number k+1. Its new value is visible on `latchStat` one clock after the write.
- R3: A fast-access write with bit k of `fastWrData` set, and bit 8+k clear, clears latch k. To assert select number n, write bit n−1 of the lower lane. With inversion off, this drives `pinOut[n-1]` low.
- R4: When the set bit and the clear bit of the same pin are both 1 in one write, that latch keeps its value. A pin whose two bits are both 0 also keeps its value.
- R5: `pinOut[k]` equals latch k XOR inversion bit k. Inversion bit k is bit k of the last configuration write.
- R6: A configuration write replaces every role bit and every inversion bit. Bit 8+k of `cfgWrData` marks pin k as a chip select, and this is reported on `csMode[k]` one clock later.
- R7: In a cycle with neither write strobe, `latchStat`, `csMode` and `pinOut` keep their values.
- R8: Writing 0x00FF..0xFF00 style masks works as bulk operations. Writing 0xFF00 sets every latch, which releases every select and drives all non-inverted pins high.
- R9: Bits of either lane at positions NUM_PINS and above are ignored in both registers. This holds for the 3-pin and the 6-pin build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Role bits in the upper lane, inversion bits in the lower lane |
| fastWrEn | input | 1 | Fast-access write strobe |
| fastWrData | input | 16 | Set mask in the upper lane, clear mask in the lower lane |
| pinOut | output | NUM_PINS | Pin levels |
| latchStat | output | NUM_PINS | Current latch values |
| csMode | output | NUM_PINS | Per-pin chip-select role |

## Verification
The assertions check the following on every cycle:
- a write with a set-only bit leaves that latch at 1;
- a write with a clear-only bit leaves that latch at 0;
- a conflicting or empty pair of bits leaves the latch untouched;
- an idle cycle changes nothing;
- the relation between pin level and latch moves only on a configuration write;
- the role bits follow the configuration data.

The absolute values need the bench's scenarios: the reset state, the exact pin levels for every polarity pattern, the 1-based numbering of individual selects, and the masking of lane bits beyond the pin count in the 3-pin build.

// File: rtl/cs_pin_pkg.sv
package cs_pin_pkg;
  localparam int LANE_W = 8;
  localparam int REG_W  = 2 * LANE_W;

  typedef struct packed {
    logic              latchWr;
    logic [LANE_W-1:0] setMask;
    logic [LANE_W-1:0] clrMask;
    logic              cfgWr;
    logic [LANE_W-1:0] csBits;
    logic [LANE_W-1:0] invBits;
  } csStrobe_t;
endpackage

// File: rtl/cs_pin_dec.sv
module cs_pin_dec
  import cs_pin_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             fastWrEn,
  input  logic [REG_W-1:0] fastWrData,
  output csStrobe_t        strb
);
  // lanes beyond the implemented pins never reach the datapath
  localparam logic [LANE_W-1:0] PIN_MASK = LANE_W'((1 << NUM_PINS) - 1);

  always_comb begin
    strb.latchWr = fastWrEn;
    strb.setMask = fastWrData[LANE_W +: LANE_W] & PIN_MASK;
    strb.clrMask = fastWrData[0 +: LANE_W] & PIN_MASK;
    strb.cfgWr   = cfgWrEn;
    strb.csBits  = cfgWrData[LANE_W +: LANE_W] & PIN_MASK;
    strb.invBits = cfgWrData[0 +: LANE_W] & PIN_MASK;
  end
endmodule

// File: rtl/cs_pin_dp.sv
module cs_pin_dp
  import cs_pin_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  csStrobe_t           strb,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] latchQ,
  output logic [NUM_PINS-1:0] csQ
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic latchBit;
    logic invBit;
    logic csBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latchBit <= 1'b0;
      end else if (strb.latchWr) begin
        unique case ({strb.setMask[i], strb.clrMask[i]})
          2'b10:   latchBit <= 1'b1;
          2'b01:   latchBit <= 1'b0;
          default: latchBit <= latchBit;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        invBit <= 1'b0;
        csBit  <= 1'b0;
      end else if (strb.cfgWr) begin
        invBit <= strb.invBits[i];
        csBit  <= strb.csBits[i];
      end
    end

    assign latchQ[i] = latchBit;
    assign csQ[i]    = csBit;
    assign pinOut[i] = latchBit ^ invBit;
  end
endmodule

// File: rtl/cs_pin_ctrl.sv
module cs_pin_ctrl
  import cs_pin_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [REG_W-1:0]    cfgWrData,
  input  logic                fastWrEn,
  input  logic [REG_W-1:0]    fastWrData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] latchStat,
  output logic [NUM_PINS-1:0] csMode
);
  csStrobe_t strb;

  cs_pin_dec #(.NUM_PINS(NUM_PINS)) u_dec (
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .fastWrEn   (fastWrEn),
    .fastWrData (fastWrData),
    .strb       (strb)
  );

  cs_pin_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pinOut (pinOut),
    .latchQ (latchStat),
    .csQ    (csMode)
  );
endmodule

// File: rtl/cs_pin_ctrl_chk.sv
module cs_pin_ctrl_chk
  import cs_pin_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic [REG_W-1:0]    cfgWrData,
  input logic                fastWrEn,
  input logic [REG_W-1:0]    fastWrData,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] latchStat,
  input logic [NUM_PINS-1:0] csMode
);
  logic [NUM_PINS-1:0] setLane, clrLane, setOnly, clrOnly, keepMask;
  assign setLane  = fastWrData[LANE_W +: NUM_PINS];
  assign clrLane  = fastWrData[0 +: NUM_PINS];
  assign setOnly  = setLane & ~clrLane;
  assign clrOnly  = clrLane & ~setLane;
  assign keepMask = ~(setOnly | clrOnly);

  AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    fastWrEn |=> ((latchStat & $past(setOnly)) == $past(setOnly)));  // R2
  AST_CLR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    fastWrEn |=> ((latchStat & $past(clrOnly)) == '0));  // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fastWrEn |=> (((latchStat ^ $past(latchStat)) & $past(keepMask)) == '0));  // R4
  AST_POLARITY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(pinOut ^ latchStat));  // R5
  AST_ROLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (csMode == $past(cfgWrData[LANE_W +: NUM_PINS])));  // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !fastWrEn) |=> ($stable(latchStat) && $stable(pinOut) && $stable(csMode)));  // R7
endmodule

bind cs_pin_ctrl cs_pin_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .fastWrEn   (fastWrEn),
  .fastWrData (fastWrData),
  .pinOut     (pinOut),
  .latchStat  (latchStat),
  .csMode     (csMode)
);

// File: tb/cs_pin_ctrl_bench.sv
module cs_pin_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        fastWrEn = 1'b0;
  logic [15:0] fastWrData = '0;
  logic [5:0]  pinOut6, latchStat6, csMode6;
  logic [2:0]  pinOut3, latchStat3, csMode3;

  int checks = 0;
  int failures = 0;

  logic [5:0] expLatch6 = '0, expInv6 = '0, expCs6 = '0;
  logic [2:0] expLatch3 = '0, expInv3 = '0, expCs3 = '0;

  always #4 clk = ~clk;

  cs_pin_ctrl #(.NUM_PINS(6)) u_cs_pin_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .fastWrEn(fastWrEn), .fastWrData(fastWrData),
    .pinOut(pinOut6), .latchStat(latchStat6), .csMode(csMode6)
  );

  cs_pin_ctrl #(.NUM_PINS(3)) u_cs_pin_ctrl_n3 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .fastWrEn(fastWrEn), .fastWrData(fastWrData),
    .pinOut(pinOut3), .latchStat(latchStat3), .csMode(csMode3)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nextLatch(input logic [7:0] cur, input logic [7:0] s,
                                           input logic [7:0] c);
    return (cur & ~(c & ~s)) | (s & ~c);
  endfunction

  task automatic checkAll(input string req);
    chk({req, " latch6"}, {2'b0, latchStat6}, {2'b0, expLatch6});
    chk({req, " pin6"}, {2'b0, pinOut6}, {2'b0, expLatch6 ^ expInv6});
    chk({req, " latch3"}, {5'b0, latchStat3}, {5'b0, expLatch3});
    chk({req, " pin3"}, {5'b0, pinOut3}, {5'b0, expLatch3 ^ expInv3});
  endtask

  // drive at a falling edge, sample at the next falling edge (one rising edge later)
  task automatic fastWrite(input logic [15:0] d);
    logic [7:0] n;
    @(negedge clk);
    fastWrEn = 1'b1;
    fastWrData = d;
    @(negedge clk);
    fastWrEn = 1'b0;
    fastWrData = 16'h0;
    n = nextLatch({2'b0, expLatch6}, d[15:8], d[7:0]);
    expLatch6 = n[5:0];
    n = nextLatch({5'b0, expLatch3}, d[15:8], d[7:0]);
    expLatch3 = n[2:0];
  endtask

  task automatic cfgWrite(input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    cfgWrData = 16'h0;
    expInv6 = d[5:0];
    expCs6  = d[13:8];
    expInv3 = d[2:0];
    expCs3  = d[10:8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 latch6", {2'b0, latchStat6}, 8'h0);
    chk("R1 cs6", {2'b0, csMode6}, 8'h0);
    chk("R1 pin6", {2'b0, pinOut6}, 8'h0);
    chk("R1 latch3", {5'b0, latchStat3}, 8'h0);

    // R8 release all selects
    fastWrite(16'hFF00);
    chk("R8 latch6", {2'b0, latchStat6}, 8'h3F);
    chk("R8 pin6", {2'b0, pinOut6}, 8'h3F);
    chk("R8 pin3", {5'b0, pinOut3}, 8'h07);

    // R3 numbering: assert select n by clearing bit n-1, then release (R2)
    for (int n = 1; n <= 6; n++) begin
      fastWrite(16'h0001 << (n - 1));
      chk("R3 select low", {2'b0, pinOut6}, 8'h3F & ~(8'h01 << (n - 1)));
      fastWrite(16'h0100 << (n - 1));
      chk("R2 select release", {2'b0, pinOut6}, 8'h3F);
    end

    // R4 conflicting pair holds
    fastWrite(16'h0101);
    chk("R4 both bits hold", {2'b0, latchStat6}, 8'h3F);
    fastWrite(16'h0038);
    fastWrite(16'h0808);
    chk("R4 both bits hold low", {2'b0, latchStat6}, 8'h07);

    // R2 R3 R4 R9 sweep of set and clear lanes, checked against arithmetic model
    for (int s = 0; s < 256; s++) begin
      fastWrite({s[7:0], 8'((s * 37 + 11) & 8'hFF)});
      checkAll("R2 R3 R4 R9 sweep");
    end
    for (int c = 0; c < 256; c++) begin
      fastWrite({8'((c * 73 + 5) & 8'hFF), c[7:0]});
      checkAll("R2 R3 R4 R9 sweep");
    end

    // R5 R6 R9 polarity and role sweep, including bits past the pin count
    for (int v = 0; v < 256; v++) begin
      cfgWrite({8'(v ^ 8'hA5), v[7:0]});
      chk("R6 cs6", {2'b0, csMode6}, {2'b0, expCs6});
      chk("R9 cs3", {5'b0, csMode3}, {5'b0, expCs3});
      checkAll("R5 polarity");
      fastWrite({8'(v * 3), 8'(v * 5)});
      checkAll("R5 polarity after latch write");
    end

    // R7 idle cycles leave everything unchanged
    repeat (4) @(negedge clk);
    checkAll("R7 idle");
    chk("R7 cs6", {2'b0, csMode6}, {2'b0, expCs6});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule